// File: doc/BRIEF.md
# Sampled Fault-Request Detector

This block watches four active-low fault request lines and decides, one channel at a time, when a line carries a real request to tri-state a set of power outputs. Each line first passes through a two-flop synchronizer. A per-channel two-bit mode then picks how a request is recognised. One choice reacts to a single high-to-low transition. The other three accept a request only after sixteen back-to-back low samples, taken on enable ticks from a shared free-running prescaler at one eighth, one sixteenth or one hundred-twenty-eighth of the clock rate.

An accepted request sets a sticky per-channel flag. The flag drives that channel's high-impedance request output directly. The flags, ORed together and gated by an enable bit, form one interrupt line. A 16-bit control/status word sits on a simple synchronous bus and holds the modes, the enable and the flags. The mode bits take exactly one write after reset and then stay fixed. A flag can be cleared only after software has seen it as 1 in a read, which guards against losing a request that arrives unseen.

Top module: `fault_req_detector`

## Requirements
- R1: After reset the status word reads 0x0000, every `hiz_req` bit is 0 and `irq` is 0.
- R2: Bits [2c+1:2c] hold channel c's mode: 00 = falling edge, 01 = 16 low samples at clk/8, 10 = at clk/16, 11 = at clk/128. The first write after reset stores them.
- R3: Once the first write has happened, later writes leave the mode bits unchanged. Bit 8 (interrupt enable) stays writable at any time.
- R4: In mode 00 a high-to-low transition on the synchronized input sets the channel's flag.
- R5: In the sampled modes the flag sets once 16 consecutive sampling ticks have seen the input low. A tick that sees it high restarts the count, so shorter or interrupted low periods set nothing.
- R6: In the sampled modes a request is accepted only once per low period: after a clear, the flag stays 0 while the input remains low.
- R7: Writing 0 to flag bit 12+c clears flag c only if a read has returned that flag as 1 since it last set. Without such a read the write is ignored.
- R8: Writing 1 to a flag bit never changes the flag.
- R9: `irq` is 1 exactly when bit 8 is 1 and at least one flag is 1.
- R10: `hiz_req[c]` equals flag c, which reads back at bit 12+c.
- R11: Bits 11:9 always read 0, and writes to them have no effect.
- R12: If a request is accepted in the same cycle as a valid clear write, the flag stays 1 and the read marker stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, valid with `bus_sel` |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current status word |
| fault_n | input | 4 | Active-low fault request lines, asynchronous |
| hiz_req | output | 4 | Per-channel high-impedance request |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound checker watches the properties that hold on every cycle: the reserved bits read zero, the interrupt is silent while the enable is 0, the modes stay fixed after the lock, a flag falls only when a write happens and the read marker for that flag was armed, and an accepted request always leaves its flag set. The bench scenarios cover what depends on timing and history. These are the exact count of 16 low ticks at each rate, the restart when a short high glitch appears, and the once-per-low-period rule. They also include the single-cycle collision between a clear write and a new edge, which the bench lines up by counting register stages from the pin to the flag.

// File: rtl/frd_pkg.sv
`timescale 1ns/1ps
package frd_pkg;

   typedef enum logic [1:0] {
      DET_EDGE  = 2'b00,
      DET_SLOW0 = 2'b01,
      DET_SLOW1 = 2'b10,
      DET_SLOW2 = 2'b11
   } det_mode_e;

   localparam int MODE_W = 2;
   localparam int N_RATE = 3;

endpackage

// File: rtl/frd_sync.sv
`timescale 1ns/1ps
module frd_sync #(
   parameter int         W      = 4,
   parameter int         STAGES = 2,
   parameter logic       RST_V  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("frd_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= {W{RST_V}};
         end else if (s == 0) begin
            chain[s] <= d_async;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/frd_prescale.sv
`timescale 1ns/1ps
module frd_prescale #(
   parameter int DIV0 = 8,
   parameter int DIV1 = 16,
   parameter int DIV2 = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic [2:0] tick
);

   localparam int CW = $clog2(DIV2);
   localparam int L0 = $clog2(DIV0);
   localparam int L1 = $clog2(DIV1);
   localparam int L2 = $clog2(DIV2);

   if ((1 << L0) != DIV0 || (1 << L1) != DIV1 || (1 << L2) != DIV2) begin : g_bad_pow2
      $error("frd_prescale: divisors must be powers of two");
   end
   if (!(DIV0 >= 2 && DIV0 <= DIV1 && DIV1 <= DIV2)) begin : g_bad_order
      $error("frd_prescale: divisors must be ascending and at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   // one-cycle enables: each fires when its low-order slice wraps
   assign tick[0] = &cnt[L0-1:0];
   assign tick[1] = &cnt[L1-1:0];
   assign tick[2] = &cnt[L2-1:0];

endmodule

// File: rtl/frd_filter.sv
`timescale 1ns/1ps
module frd_filter
   import frd_pkg::*;
#(
   parameter int SAMPLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   input  logic [MODE_W-1:0] mode,
   input  logic [N_RATE-1:0] tick,
   output logic              accept
);

   localparam int CW = $clog2(SAMPLES + 1);

   if (SAMPLES < 2) begin : g_bad_samples
      $error("frd_filter: SAMPLES must be at least 2");
   end

   det_mode_e     m;
   logic          prev;
   logic          smp_en;
   logic [CW-1:0] lo_cnt;
   logic          edge_hit;
   logic          level_hit;

   assign m = det_mode_e'(mode);

   always_comb begin
      unique case (m)
         DET_SLOW0: smp_en = tick[0];
         DET_SLOW1: smp_en = tick[1];
         DET_SLOW2: smp_en = tick[2];
         default:   smp_en = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= din;
   end

   // low-sample counter saturates at SAMPLES so a held-low line fires once
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= '0;
      end else if (m == DET_EDGE) begin
         lo_cnt <= '0;
      end else if (smp_en) begin
         if (din)                            lo_cnt <= '0;
         else if (lo_cnt != CW'(SAMPLES))    lo_cnt <= lo_cnt + 1'b1;
      end
   end

   assign edge_hit  = (m == DET_EDGE) && prev && !din;
   assign level_hit = smp_en && !din && (lo_cnt == CW'(SAMPLES - 1));
   assign accept    = edge_hit || level_hit;

endmodule

// File: rtl/frd_csr.sv
`timescale 1ns/1ps
module frd_csr
   import frd_pkg::*;
#(
   parameter int N_CH  = 4,
   parameter int REG_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_sel,
   input  logic                     bus_wr,
   input  logic [REG_W-1:0]         bus_wdata,
   output logic [REG_W-1:0]         bus_rdata,
   input  logic [N_CH-1:0]          accept,
   output logic [N_CH*MODE_W-1:0]   modes,
   output logic                     int_en,
   output logic [N_CH-1:0]          flags,
   output logic [N_CH-1:0]          rd_mark,
   output logic                     mode_lock
);

   localparam int MODE_BITS = N_CH * MODE_W;
   localparam int IE_BIT    = MODE_BITS;
   localparam int FLAG_LSB  = REG_W - N_CH;

   if (IE_BIT >= FLAG_LSB) begin : g_bad_layout
      $error("frd_csr: register too narrow for the channel count");
   end

   logic            wr_stb;
   logic            rd_stb;
   logic [N_CH-1:0] clr_ok;

   assign wr_stb = bus_sel && bus_wr;
   assign rd_stb = bus_sel && !bus_wr;

   for (genvar c = 0; c < N_CH; c++) begin : g_clr
      assign clr_ok[c] = wr_stb && !bus_wdata[FLAG_LSB + c] && rd_mark[c] && flags[c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         modes     <= '0;
         mode_lock <= 1'b0;
         int_en    <= 1'b0;
      end else if (wr_stb) begin
         int_en <= bus_wdata[IE_BIT];
         if (!mode_lock) begin
            modes     <= bus_wdata[MODE_BITS-1:0];
            mode_lock <= 1'b1;
         end
      end
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[c]   <= 1'b0;
            rd_mark[c] <= 1'b0;
         end else begin
            // a fresh request outranks a clear in the same cycle
            if (accept[c])      flags[c] <= 1'b1;
            else if (clr_ok[c]) flags[c] <= 1'b0;

            if (clr_ok[c] && !accept[c])  rd_mark[c] <= 1'b0;
            else if (rd_stb && flags[c])  rd_mark[c] <= 1'b1;
         end
      end
   end

   always_comb begin
      bus_rdata                            = '0;
      bus_rdata[MODE_BITS-1:0]             = modes;
      bus_rdata[IE_BIT]                    = int_en;
      bus_rdata[FLAG_LSB +: N_CH]          = flags;
   end

endmodule

// File: rtl/fault_req_detector.sv
`timescale 1ns/1ps
module fault_req_detector
   import frd_pkg::*;
#(
   parameter int N_CH        = 4,
   parameter int REG_W       = 16,
   parameter int SAMPLES     = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DIV0        = 8,
   parameter int DIV1        = 16,
   parameter int DIV2        = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   input  logic [N_CH-1:0]  fault_n,
   output logic [N_CH-1:0]  hiz_req,
   output logic             irq
);

   localparam int MODE_BITS = N_CH * MODE_W;

   if (N_CH < 1) begin : g_bad_nch
      $error("fault_req_detector: need at least one channel");
   end

   logic [N_CH-1:0]      fault_s;
   logic [N_RATE-1:0]    tick;
   logic [N_CH-1:0]      accept;
   logic [MODE_BITS-1:0] modes;
   logic                 int_en;
   logic [N_CH-1:0]      flags;
   logic [N_CH-1:0]      rd_mark;
   logic                 mode_lock;

   frd_sync #(
      .W      (N_CH),
      .STAGES (SYNC_STAGES),
      .RST_V  (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (fault_n),
      .q_sync  (fault_s)
   );

   frd_prescale #(
      .DIV0 (DIV0),
      .DIV1 (DIV1),
      .DIV2 (DIV2)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      frd_filter #(
         .SAMPLES (SAMPLES)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .din    (fault_s[c]),
         .mode   (modes[c*MODE_W +: MODE_W]),
         .tick   (tick),
         .accept (accept[c])
      );
   end

   frd_csr #(
      .N_CH  (N_CH),
      .REG_W (REG_W)
   ) u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .accept    (accept),
      .modes     (modes),
      .int_en    (int_en),
      .flags     (flags),
      .rd_mark   (rd_mark),
      .mode_lock (mode_lock)
   );

   assign hiz_req = flags;
   assign irq     = int_en && (|flags);

endmodule

// File: rtl/frd_chk.sv
`timescale 1ns/1ps
module frd_chk #(
   parameter int N_CH  = 4,
   parameter int REG_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [REG_W-1:0] bus_rdata,
   input logic [N_CH-1:0]  hiz_req,
   input logic             irq,
   input logic [N_CH-1:0]  accept,
   input logic [N_CH-1:0]  rd_mark,
   input logic             mode_lock
);

   localparam int MODE_BITS = 2 * N_CH;
   localparam int IE_BIT    = MODE_BITS;
   localparam int FLAG_LSB  = REG_W - N_CH;

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[FLAG_LSB-1:IE_BIT+1] == '0); // R11

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rdata[IE_BIT] |-> !irq); // R9

   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      mode_lock |=> $stable(bus_rdata[MODE_BITS-1:0])); // R3

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> ((hiz_req & $past(hiz_req)) == $past(hiz_req))); // R7

   AST_CLR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hiz_req) & ~hiz_req & ~$past(rd_mark)) == '0); // R7

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|accept) |=> ((hiz_req & $past(accept)) == $past(accept))); // R12

endmodule

bind fault_req_detector frd_chk #(
   .N_CH  (N_CH),
   .REG_W (REG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .hiz_req   (hiz_req),
   .irq       (irq),
   .accept    (accept),
   .rd_mark   (rd_mark),
   .mode_lock (mode_lock)
);

// File: tb/fault_req_detector_tb.sv
`timescale 1ns/1ps
module fault_req_detector_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel;
   logic        bus_wr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;
   logic [3:0]  fault_n;
   logic [3:0]  hiz_req;
   logic        irq;

   always #10 clk = ~clk;   // 50 MHz

   fault_req_detector u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .fault_n   (fault_n),
      .hiz_req   (hiz_req),
      .irq       (irq)
   );

   int          n_cmp = 0;
   int          n_bad = 0;
   logic [15:0] exp_q [$];
   string       tag_q [$];
   event        rd_ev;

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops each expected read word and compares it with the bus
   initial begin
      forever begin
         @(rd_ev);
         if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_read(input logic [15:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bus_sel = 1'b1;
      bus_wr  = 1'b0;
      #5 ->rd_ev;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic bus_write(input logic [15:0] d);
      bus_sel   = 1'b1;
      bus_wr    = 1'b1;
      bus_wdata = d;
      @(negedge clk);
      bus_sel   = 1'b0;
      bus_wr    = 1'b0;
   endtask

   task automatic low_for(input int ch, input int n);
      fault_n[ch] = 1'b0;
      idle(n);
      fault_n[ch] = 1'b1;
      idle(6);
   endtask

   initial begin
      #(20 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      bus_sel   = 1'b0;
      bus_wr    = 1'b0;
      bus_wdata = '0;
      fault_n   = '1;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      check("R1 hiz_req", {12'h0, hiz_req}, 16'h0000);
      check("R1 irq", {15'h0, irq}, 16'h0000);
      bus_read(16'h0000, "R1 word");

      // modes: ch0 edge, ch1 /8, ch2 /16, ch3 /128; reserved bits written 1
      bus_write(16'h0EE4);
      bus_read(16'h00E4, "R2 R11 first write");
      bus_write(16'h0100);
      bus_read(16'h01E4, "R3 modes locked, enable taken");
      bus_write(16'h00E4);

      // edge on channel 0
      low_for(0, 3);
      check("R4 edge sets flag", {12'h0, hiz_req}, 16'h0001);
      check("R9 irq off while disabled", {15'h0, irq}, 16'h0000);
      bus_write(16'h00E4);
      idle(2);
      check("R7 clear without read ignored", {12'h0, hiz_req}, 16'h0001);
      bus_write(16'h01E4);
      check("R9 irq with enable", {15'h0, irq}, 16'h0001);
      bus_read(16'h11E4, "R10 flag readback");
      bus_write(16'h01E4);
      idle(1);
      check("R7 clear after read", {12'h0, hiz_req}, 16'h0000);
      check("R9 irq drops", {15'h0, irq}, 16'h0000);
      bus_write(16'hF1E4);
      bus_read(16'h01E4, "R8 write one no effect");

      // collision: new edge accepted in the cycle of a valid clear
      low_for(0, 3);
      bus_read(16'h11E4, "R12 armed");
      fault_n[0] = 1'b0;
      idle(2);
      bus_write(16'h01E4);
      check("R12 set wins", {12'h0, hiz_req}, 16'h0001);
      fault_n[0] = 1'b1;
      idle(4);
      bus_write(16'h01E4);
      idle(1);
      check("R12 marker kept", {12'h0, hiz_req}, 16'h0000);

      // channel 1, clk/8
      low_for(1, 100);
      check("R5 short low /8", {12'h0, hiz_req}, 16'h0000);
      fault_n[1] = 1'b0;
      idle(100);
      fault_n[1] = 1'b1;
      idle(20);
      low_for(1, 100);
      check("R5 glitch restarts", {12'h0, hiz_req}, 16'h0000);
      fault_n[1] = 1'b0;
      idle(200);
      check("R5 long low /8", {12'h0, hiz_req}, 16'h0002);
      bus_read(16'h21E4, "R10 ch1 flag");
      bus_write(16'h01E4);
      idle(100);
      check("R6 no re-accept while low", {12'h0, hiz_req}, 16'h0000);
      fault_n[1] = 1'b1;
      idle(6);

      // channel 2, clk/16
      low_for(2, 200);
      check("R5 short low /16", {12'h0, hiz_req}, 16'h0000);
      low_for(2, 320);
      check("R5 long low /16", {12'h0, hiz_req}, 16'h0004);
      bus_read(16'h41E4, "R10 ch2 flag");
      bus_write(16'h01E4);
      idle(2);
      check("R7 ch2 cleared", {12'h0, hiz_req}, 16'h0000);

      // channel 3, clk/128
      low_for(3, 1800);
      check("R5 short low /128", {12'h0, hiz_req}, 16'h0000);
      low_for(3, 2300);
      check("R5 long low /128", {12'h0, hiz_req}, 16'h0008);
      check("R9 irq ch3", {15'h0, irq}, 16'h0001);
      bus_read(16'h81E4, "R10 ch3 flag");

      idle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule